// File: doc/BRIEF.md
# Dual Loadable Address/Word Counter

This block holds two independent 8-bit counters, channel A and channel C, that share one 8-bit data port. Software or a sequencer preloads either counter (or both) through the port, reads back either one, and then advances them with count strobes while a transfer runs. Channel A advances either by one or, with its low bit frozen, by two, which suits byte or word addressing. Channel C always advances by one and is meant for a transfer count.

The strobes and the load input are asynchronous level signals. They are brought into the system clock domain with a synchronizer chain, and the block acts on the falling edges it sees there. Each channel raises a terminal-count output while its synchronized strobe is high and the counter sits at its maximum. When the strobe falls, the counter wraps and the terminal-count output falls with it. Tying the terminal-count output of one block to the strobe of a second block therefore builds a 16-bit counter.

The data port is a plain control port with no valid/ready handshake. The tri-state driver is modelled as a data output plus an output enable. Selects and data must be held steady while the load input is low.

Top module: `dual_addr_word_counter`

## Requirements
- R1: After reset both counters read 0x00, data_oe_o is 0 and both terminal-count outputs are 0.
- R2: A falling edge on load_n_i copies data_i into every counter whose select (sel_a_i for A, sel_c_i for C) is high. A counter that is not selected keeps its value.
- R3: With rd_i high and sel_a_i high, data_oe_o is 1 and data_o shows counter A. With rd_i high, sel_c_i high and sel_a_i low, data_o shows counter C. In every other case data_oe_o is 0 and data_o is 0x00.
- R4: With step_two_i low, each falling edge of a_stb_i adds one to counter A, modulo 256.
- R5: With step_two_i high, each falling edge of a_stb_i keeps bit 0 of counter A and adds one to bits 7:1, modulo 128.
- R6: Each falling edge of c_stb_i adds one to counter C, modulo 256, whatever the level of step_two_i.
- R7: tc_a_o is high exactly while the synchronized a_stb_i is high and counter A is at its maximum. The maximum is 0xFF when stepping by one, and bits 7:1 all ones (0xFE or 0xFF) when stepping by two.
- R8: tc_c_o is high exactly while the synchronized c_stb_i is high and counter C equals 0xFF.
- R9: A counter changes only on a falling edge of its own strobe or on a load. A rising strobe edge and the other channel's strobe leave it unchanged.
- R10: Two blocks cascaded through tc_a_o, with the high block stepping by one, carry 0x00FF to 0x0100 on a single strobe.
- R11: A strobe that stays low or stays high for any number of clocks produces at most one count per falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_stb_i | input | 1 | Count strobe for counter A, asynchronous, counts on falling edge |
| c_stb_i | input | 1 | Count strobe for counter C, asynchronous, counts on falling edge |
| step_two_i | input | 1 | 1: counter A steps by two with bit 0 held; 0: steps by one |
| load_n_i | input | 1 | Load strobe, asynchronous, loads on falling edge |
| sel_a_i | input | 1 | Selects counter A for load and read |
| sel_c_i | input | 1 | Selects counter C for load and read |
| rd_i | input | 1 | Read enable for the data port |
| data_i | input | 8 | Load data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Output enable of the data port driver |
| tc_a_o | output | 1 | Terminal-count output of counter A |
| tc_c_o | output | 1 | Terminal-count output of counter C |

## Verification
The hardest situation to reach is a carry into a second block. It needs the low counter parked at its maximum and the terminal-count pulse passing through the second block's own synchronizer. The bench instantiates two blocks, preloads 0x00FF through the ports and issues one strobe, then reads both halves after the carry has settled. The terminal-count window is swept in both step modes over every counter value. In step-by-two mode the sweep is repeated with bit 0 preloaded as 1, since this is the only way to see the odd maximum.

// File: rtl/dual_ctr_pkg.sv
package dual_ctr_pkg;
  typedef enum logic {
    STEP_ONE = 1'b0,
    STEP_TWO = 1'b1
  } step_e;

  localparam int NUM_CH = 2;
  localparam int CH_A   = 0;
  localparam int CH_C   = 1;
endpackage

// File: rtl/dctr_sync_fall.sv
module dctr_sync_fall #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= {STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level_o = sh_q[STAGES-1];
  assign fall_o  = prev_q & ~sh_q[STAGES-1];

  // R11
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dctr_count_cell.sv
module dctr_count_cell
  import dual_ctr_pkg::*;
#(
  parameter int W       = 8,
  parameter bit HAS_TWO = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] ld_data_i,
  input  step_e        step_i,
  input  logic         level_i,
  output logic [W-1:0] count_o,
  output logic         tc_o
);
  localparam logic [W-2:0] HI_ONE  = {{(W-2){1'b0}}, 1'b1};
  localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

  logic [W-1:0] count_q;
  logic [W-1:0] next_inc;
  logic         two_eff;
  logic         at_max;

  assign two_eff = HAS_TWO && (step_i == STEP_TWO);

  always_comb begin
    if (two_eff) begin
      next_inc = {count_q[W-1:1] + HI_ONE, count_q[0]};
      at_max   = &count_q[W-1:1];
    end else begin
      next_inc = count_q + 1'b1;
      at_max   = &count_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (load_i) count_q <= ld_data_i;
    else if (inc_i)  count_q <= next_inc;
  end

  assign count_o = count_q;
  assign tc_o    = level_i & at_max;

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(count_q));
  // R2
  load_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_q == $past(ld_data_i));
  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && !two_eff && count_q == ALL_ONE) |=> count_q == '0);
  // R5
  lsb_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && two_eff) |=> count_q[0] == $past(count_q[0]));
endmodule

// File: rtl/dual_addr_word_counter.sv
module dual_addr_word_counter
  import dual_ctr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_stb_i,
  input  logic              c_stb_i,
  input  logic              step_two_i,
  input  logic              load_n_i,
  input  logic              sel_a_i,
  input  logic              sel_c_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              tc_a_o,
  output logic              tc_c_o
);
  logic [NUM_CH-1:0] stb_raw, stb_lvl, stb_fall, sel, tc;
  logic [DATA_W-1:0] cnt [NUM_CH];
  logic              load_lvl, load_fall;
  step_e             step;

  assign stb_raw = {c_stb_i, a_stb_i};
  assign sel     = {sel_c_i, sel_a_i};
  assign step    = step_two_i ? STEP_TWO : STEP_ONE;

  dctr_sync_fall #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) load_sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(load_n_i),
    .level_o(load_lvl), .fall_o(load_fall)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dctr_sync_fall #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) stb_sync_i (
      .clk(clk), .rst_n(rst_n), .async_i(stb_raw[ch]),
      .level_o(stb_lvl[ch]), .fall_o(stb_fall[ch])
    );
    dctr_count_cell #(.W(DATA_W), .HAS_TWO(ch == CH_A)) cell_i (
      .clk(clk), .rst_n(rst_n),
      .inc_i(stb_fall[ch]),
      .load_i(load_fall & sel[ch]),
      .ld_data_i(data_i),
      .step_i(step),
      .level_i(stb_lvl[ch]),
      .count_o(cnt[ch]),
      .tc_o(tc[ch])
    );
  end

  always_comb begin
    data_oe_o = 1'b0;
    data_o    = '0;
    if (rd_i && sel_a_i) begin
      data_oe_o = 1'b1;
      data_o    = cnt[CH_A];
    end else if (rd_i && sel_c_i) begin
      data_oe_o = 1'b1;
      data_o    = cnt[CH_C];
    end
  end

  assign tc_a_o = tc[CH_A];
  assign tc_c_o = tc[CH_C];

  // R3
  read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel_a_i) |-> (data_oe_o && data_o == cnt[CH_A]));
  // R3
  no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |-> !data_oe_o);
  // R11
  load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |-> !load_lvl);
  // R8
  tc_c_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_c_o |-> (stb_lvl[CH_C] && cnt[CH_C] == {DATA_W{1'b1}}));
endmodule

// File: tb/dual_addr_word_counter_tb_top.sv
`timescale 1ns/1ps
module dual_addr_word_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_stb = 0, c_stb = 0, step_two = 0, load_n = 1, sel_a = 0, sel_c = 0, rd = 0;
  logic [7:0] data = 0;
  logic [7:0] dout;
  logic oe, tc_a, tc_c;
  logic hi_load_n = 1, hi_sel_a = 0, hi_rd = 0;
  logic [7:0] hi_data = 0;
  logic [7:0] hi_dout;
  logic hi_oe, hi_tc_a, hi_tc_c;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_addr_word_counter dut_i (
    .clk(clk), .rst_n(rst_n), .a_stb_i(a_stb), .c_stb_i(c_stb),
    .step_two_i(step_two), .load_n_i(load_n), .sel_a_i(sel_a), .sel_c_i(sel_c),
    .rd_i(rd), .data_i(data), .data_o(dout), .data_oe_o(oe),
    .tc_a_o(tc_a), .tc_c_o(tc_c)
  );

  dual_addr_word_counter hi_i (
    .clk(clk), .rst_n(rst_n), .a_stb_i(tc_a), .c_stb_i(1'b0),
    .step_two_i(1'b0), .load_n_i(hi_load_n), .sel_a_i(hi_sel_a), .sel_c_i(1'b0),
    .rd_i(hi_rd), .data_i(hi_data), .data_o(hi_dout), .data_oe_o(hi_oe),
    .tc_a_o(hi_tc_a), .tc_c_o(hi_tc_c)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_ch(input bit use_c, output logic [7:0] v);
    sel_a = !use_c; sel_c = use_c; rd = 1;
    tick(1);
    v = dout;
    rd = 0; sel_a = 0; sel_c = 0;
    tick(1);
  endtask

  task automatic load(input bit la, input bit lc, input logic [7:0] v);
    data = v; sel_a = la; sel_c = lc;
    tick(1);
    load_n = 0; tick(5);
    load_n = 1; tick(5);
    sel_a = 0; sel_c = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v, m;
    tick(5);
    rst_n = 1;
    tick(2);
    // R1 reset state
    chk("R1 oe", oe, 0);
    chk("R1 tc_a", tc_a, 0);
    chk("R1 tc_c", tc_c, 0);
    rd_ch(0, v); chk("R1 A", v, 0);
    rd_ch(1, v); chk("R1 C", v, 0);

    // R2 loads, R3 reads
    load(1, 0, 8'h5A);
    rd_ch(0, v); chk("R2 A load", v, 8'h5A);
    rd_ch(1, v); chk("R2 C untouched", v, 0);
    load(0, 1, 8'hC3);
    rd_ch(1, v); chk("R2 C load", v, 8'hC3);
    rd_ch(0, v); chk("R2 A untouched", v, 8'h5A);
    sel_a = 1; sel_c = 1; rd = 1; tick(1);
    chk("R3 A priority", dout, 8'h5A);
    rd = 0; tick(1);
    chk("R3 no read oe", oe, 0);
    chk("R3 no read data", dout, 0);
    sel_a = 0; sel_c = 0; rd = 1; tick(1);
    chk("R3 no select oe", oe, 0);
    rd = 0;
    load(1, 1, 8'h11);
    rd_ch(0, v); chk("R2 both A", v, 8'h11);
    rd_ch(1, v); chk("R2 both C", v, 8'h11);

    // R4/R7 step-by-one full sweep
    step_two = 0;
    load(1, 0, 8'h00);
    m = 0;
    for (int i = 0; i < 256; i++) begin
      a_stb = 1; tick(4);
      chk("R7 tc_a step one", tc_a, (m == 8'hFF));
      a_stb = 0; tick(6);
      m = m + 1;
      rd_ch(0, v); chk("R4 A step one", v, m);
    end
    chk("R7 tc_a low after wrap", tc_a, 0);
    rd_ch(1, v); chk("R9 C unaffected by A strobes", v, 8'h11);

    // R5/R7 step-by-two, even and odd start
    step_two = 1;
    for (int s = 0; s < 2; s++) begin
      load(1, 0, s[7:0]);
      m = s[7:0];
      for (int i = 0; i < 130; i++) begin
        a_stb = 1; tick(4);
        chk("R7 tc_a step two", tc_a, (m[7:1] == 7'h7F));
        a_stb = 0; tick(6);
        m = {m[7:1] + 7'd1, m[0]};
        rd_ch(0, v); chk("R5 A step two", v, m);
      end
    end

    // R6/R8 C sweep with step_two high
    load(0, 1, 8'h00);
    m = 0;
    for (int i = 0; i < 257; i++) begin
      c_stb = 1; tick(4);
      chk("R8 tc_c", tc_c, (m == 8'hFF));
      c_stb = 0; tick(6);
      m = m + 1;
      rd_ch(1, v); chk("R6 C step", v, m);
    end
    step_two = 0;

    // R9 rising edge alone, R11 long levels
    load(1, 0, 8'h40);
    a_stb = 1; tick(20);
    rd_ch(0, v); chk("R9 rising edge no count", v, 8'h40);
    a_stb = 0; tick(20);
    rd_ch(0, v); chk("R11 one count per fall", v, 8'h41);
    tick(20);
    rd_ch(0, v); chk("R11 low level no count", v, 8'h41);

    // R10 cascade 0x00FF -> 0x0100
    load(1, 0, 8'hFF);
    hi_data = 8'h00; hi_sel_a = 1; tick(1);
    hi_load_n = 0; tick(5); hi_load_n = 1; tick(5); hi_sel_a = 0;
    a_stb = 1; tick(4); a_stb = 0; tick(12);
    rd_ch(0, v); chk("R10 low byte", v, 8'h00);
    hi_sel_a = 1; hi_rd = 1; tick(1);
    chk("R10 high byte", hi_dout, 8'h01);
    hi_rd = 0; hi_sel_a = 0;
    a_stb = 1; tick(4); a_stb = 0; tick(12);
    rd_ch(0, v); chk("R10 low next", v, 8'h01);
    hi_sel_a = 1; hi_rd = 1; tick(1);
    chk("R10 high no spurious carry", hi_dout, 8'h01);
    hi_rd = 0; hi_sel_a = 0;

    done = 1;
    summary();
  end
endmodule